// File: doc/BRIEF.md
# Double-Buffered Quad DAC Register Controller

This block sits behind a serial receiver in a four-channel converter. Each time chip select rises, the receiver hands over the finished command word and the number of bits it counted. The block keeps two 12-bit registers for every channel. The staging register takes new codes. The output register holds the code that the converter sees. A 4-bit opcode at the head of each word decides what happens. It can stage one channel, stage one channel and commit all of them, commit every staged code, or write a single code into all eight registers. It can also drive a general-purpose output pin, switch the serial readback edge (which commits as well), or request a low-power shutdown.

A shutdown request takes effect only while the lockout pin is high. While in shutdown, a falling edge on that pin returns the block to normal operation. The codes are untouched, so the earlier outputs come back as they were. The command stream uses valid/ready signalling, but `cmd_ready` is always high: a word is taken in the cycle its strobe is seen, and the sender never has to wait. A word is executed only if exactly 16 bits were counted. The asynchronous active-low clear gives the same state as power-up.

Top module: `qdac_regctl`

## Requirements
- R1: After the clear is asserted, all eight registers read zero, `shutdown` is 0, `user_out` is 0, `out_mode` is 0, and `cmd_ready` is 1.
- R2: The word layout is bits [15:14] = channel select (0..3 picks code slot 0..3), bits [13:12] = control, bits [11:0] = data. With control 01, only the selected staging register takes the data, and no output code changes.
- R3: With control 11, the selected staging register takes the data. Then all four output registers copy the staging registers, so the selected channel shows the new data.
- R4: Opcode 0x4 (bits [15:12]) copies every staging register into its output register.
- R5: Opcode 0x8 writes the data field into all four staging registers and all four output registers.
- R6: Opcode 0xC sets `shutdown` only while `sd_allow` is high. Codes are kept through shutdown.
- R7: Opcode 0x2 drives `user_out` low, opcode 0x6 drives it high, and opcode 0x0 changes nothing.
- R8: Opcode 0xE sets `out_mode` to 1 and opcode 0xA sets it to 0. Both also commit all staging registers to the outputs.
- R9: A strobed word whose `cmd_len` is not 16 changes no register or output.
- R10: Every command that commits outputs (0x4, 0x8, 0xA, 0xE and control 11) clears `shutdown`.
- R11: A high-to-low transition of `sd_allow` during shutdown clears `shutdown` within four clocks and leaves every code unchanged.
- R12: The results of an executed word appear at the outputs on the clock edge after the strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| sd_allow | input | 1 | Lockout pin: high permits shutdown; its falling edge wakes the block (asynchronous, synchronised inside) |
| cmd_valid | input | 1 | One-cycle strobe: a completed word is present |
| cmd_ready | output | 1 | Always high; the block never applies back-pressure |
| cmd_word | input | 16 | Command word, opcode in the top four bits |
| cmd_len | input | 6 | Number of bits counted while chip select was low |
| dac_codes | output | 48 | Output codes, channel n in bits [12n+11:12n] |
| shutdown | output | 1 | Software shutdown active |
| user_out | output | 1 | General-purpose output bit |
| out_mode | output | 1 | Readback edge: 0 falling, 1 rising |

## Verification
All sixteen opcodes are crossed with eight data patterns, including all-ones and all-zeros. Each combination is sent with lengths of 16, 15 and 17 bits. This separates words that must execute from words that must be discarded. Because staging and committing are interleaved across channels, the sweep shows whether a committed code came from its own channel's staging register and whether a load leaked into the outputs early. Separate sequences move the lockout pin around shutdown requests. A clear issued in the middle of the run checks that every register returns to zero.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  typedef struct packed {
    logic bcast;
    logic update;
    logic sd_req;
    logic user_wr;
    logic user_val;
    logic mode_wr;
    logic mode_val;
  } qdac_act_t;
endpackage

// File: rtl/qdac_decode.sv
module qdac_decode #(
  parameter int NCH   = 4,
  parameter int DW    = 12,
  parameter int LEN_W = 6
) (
  input  logic                        cmd_valid,
  input  logic [$clog2(NCH)+2+DW-1:0] cmd_word,
  input  logic [LEN_W-1:0]            cmd_len,
  output logic [NCH-1:0]              load_sel,
  output logic [DW-1:0]               data,
  output qdac_pkg::qdac_act_t         act
);
  localparam int AW     = $clog2(NCH);
  localparam int WORD_W = AW + 2 + DW;
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(WORD_W);

  logic          exec;
  logic [AW-1:0] sel;
  logic [1:0]    ctl;

  assign exec = cmd_valid && (cmd_len == FULL_LEN);
  assign sel  = cmd_word[WORD_W-1 -: AW];
  assign ctl  = cmd_word[DW+1:DW];
  assign data = cmd_word[DW-1:0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_sel
    assign load_sel[ch] = exec && ctl[0] && (sel == AW'(ch));
  end

  always_comb begin
    act = '0;
    if (exec) begin
      unique case (ctl)
        2'b11: act.update = 1'b1;
        2'b00: begin
          if (sel == AW'(1)) act.update = 1'b1;
          if (sel == AW'(2)) act.bcast  = 1'b1;
          if (sel == AW'(3)) act.sd_req = 1'b1;
        end
        2'b10: begin
          if (sel == AW'(0) || sel == AW'(1)) begin
            act.user_wr  = 1'b1;
            act.user_val = sel[0];
          end else begin
            act.mode_wr  = 1'b1;
            act.mode_val = sel[0];
            act.update   = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank #(
  parameter int NCH = 4,
  parameter int DW  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    load_sel,
  input  logic              bcast,
  input  logic              update,
  input  logic [DW-1:0]     data,
  output logic [NCH*DW-1:0] codes
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0] stage_q;
    logic [DW-1:0] out_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        out_q   <= '0;
      end else begin
        if (bcast || load_sel[ch]) stage_q <= data;
        if (bcast)       out_q <= data;
        else if (update) out_q <= load_sel[ch] ? data : stage_q;
      end
    end

    assign codes[ch*DW +: DW] = out_q;
  end
endmodule

// File: rtl/qdac_ctrl.sv
module qdac_ctrl (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sd_allow,
  input  qdac_pkg::qdac_act_t act,
  output logic                shutdown,
  output logic                user_out,
  output logic                out_mode
);
  logic lk_s1, lk_s2, lk_prev, lk_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_s1   <= 1'b0;
      lk_s2   <= 1'b0;
      lk_prev <= 1'b0;
    end else begin
      lk_s1   <= sd_allow;
      lk_s2   <= lk_s1;
      lk_prev <= lk_s2;
    end
  end

  assign lk_fall = lk_prev && !lk_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shutdown <= 1'b0;
      user_out <= 1'b0;
      out_mode <= 1'b0;
    end else begin
      if (act.update || act.bcast || lk_fall) shutdown <= 1'b0;
      else if (act.sd_req && lk_s2)           shutdown <= 1'b1;
      if (act.user_wr) user_out <= act.user_val;
      if (act.mode_wr) out_mode <= act.mode_val;
    end
  end
endmodule

// File: rtl/qdac_regctl.sv
module qdac_regctl #(
  parameter int NCH   = 4,
  parameter int DW    = 12,
  parameter int LEN_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sd_allow,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic [$clog2(NCH)+2+DW-1:0] cmd_word,
  input  logic [LEN_W-1:0]            cmd_len,
  output logic [NCH*DW-1:0]           dac_codes,
  output logic                        shutdown,
  output logic                        user_out,
  output logic                        out_mode
);
  logic [NCH-1:0]      load_sel;
  logic [DW-1:0]       data;
  qdac_pkg::qdac_act_t act;

  assign cmd_ready = 1'b1;

  qdac_decode #(.NCH(NCH), .DW(DW), .LEN_W(LEN_W)) u_dec (
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_len(cmd_len),
    .load_sel(load_sel), .data(data), .act(act)
  );

  qdac_regbank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .load_sel(load_sel), .bcast(act.bcast),
    .update(act.update), .data(data), .codes(dac_codes)
  );

  qdac_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sd_allow(sd_allow), .act(act),
    .shutdown(shutdown), .user_out(user_out), .out_mode(out_mode)
  );
endmodule

// File: rtl/qdac_regctl_chk.sv
module qdac_regctl_chk #(
  parameter int NCH   = 4,
  parameter int DW    = 12,
  parameter int LEN_W = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cmd_valid,
  input logic [$clog2(NCH)+2+DW-1:0] cmd_word,
  input logic [LEN_W-1:0]            cmd_len,
  input logic [NCH*DW-1:0]           dac_codes,
  input logic                        shutdown,
  input logic                        user_out,
  input logic                        out_mode
);
  localparam int WORD_W = $clog2(NCH) + 2 + DW;
  logic       exec;
  logic [3:0] op;
  assign exec = cmd_valid && (cmd_len == LEN_W'(WORD_W));
  assign op   = cmd_word[WORD_W-1 -: 4];

  a_r2_load_holds_out: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op[1:0] == 2'b01 |=> $stable(dac_codes));

  a_r9_short_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !exec |=> $stable(dac_codes) && $stable(user_out) && $stable(out_mode));

  a_r6_sd_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown) |-> $past(exec) && $past(op) == 4'hC);

  a_r7_user_high: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == 4'h6 |=> user_out);

  a_r7_user_low: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == 4'h2 |=> !user_out);

  a_r8_mode_rise: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == 4'hE |=> out_mode);

  a_r10_commit_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    exec && (op == 4'h4 || op == 4'h8 || op == 4'hA || op == 4'hE || op[1:0] == 2'b11)
    |=> !shutdown);
endmodule

bind qdac_regctl qdac_regctl_chk #(.NCH(NCH), .DW(DW), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .cmd_len(cmd_len), .dac_codes(dac_codes), .shutdown(shutdown),
  .user_out(user_out), .out_mode(out_mode)
);

// File: tb/qdac_regctl_bench.sv
module qdac_regctl_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sd_allow = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_word = '0;
  logic [5:0]  cmd_len = '0;
  logic [47:0] dac_codes;
  logic        shutdown, user_out, out_mode;

  int vectors = 0;
  int fails = 0;

  logic [11:0] st_m [4];
  logic [11:0] out_m [4];
  logic sd_m, up_m, md_m;

  always #(CLK_P/2) clk = ~clk;

  qdac_regctl u_qdac_regctl (
    .clk(clk), .rst_n(rst_n), .sd_allow(sd_allow), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_word(cmd_word), .cmd_len(cmd_len),
    .dac_codes(dac_codes), .shutdown(shutdown), .user_out(user_out),
    .out_mode(out_mode)
  );

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin st_m[i] = '0; out_m[i] = '0; end
    sd_m = 0; up_m = 0; md_m = 0;
  endtask

  task automatic compare(input string req);
    vectors++;
    for (int i = 0; i < 4; i++) begin
      if (dac_codes[i*12 +: 12] !== out_m[i]) begin
        fails++;
        $display("FAIL %s ch%0d code act=%h exp=%h word=%h len=%0d", req, i,
                 dac_codes[i*12 +: 12], out_m[i], cmd_word, cmd_len);
      end
    end
    if (shutdown !== sd_m || user_out !== up_m || out_mode !== md_m || cmd_ready !== 1'b1) begin
      fails++;
      $display("FAIL %s flags act=%b%b%b%b exp=%b%b%b1 word=%h", req,
               shutdown, user_out, out_mode, cmd_ready, sd_m, up_m, md_m, cmd_word);
    end
  endtask

  // Expected effect of a word, written from the requirement list (R2-R10).
  task automatic model_apply(input logic [15:0] w, input int len);
    logic [1:0] a; logic [1:0] c; logic [11:0] d;
    a = w[15:14]; c = w[13:12]; d = w[11:0];
    if (len != 16) return;
    if (c == 2'b01) st_m[a] = d;
    else if (c == 2'b11) begin
      st_m[a] = d;
      for (int i = 0; i < 4; i++) out_m[i] = st_m[i];
      sd_m = 0;
    end else if (c == 2'b00) begin
      if (a == 1) begin for (int i = 0; i < 4; i++) out_m[i] = st_m[i]; sd_m = 0; end
      if (a == 2) begin for (int i = 0; i < 4; i++) begin st_m[i] = d; out_m[i] = d; end sd_m = 0; end
      if (a == 3 && sd_allow) sd_m = 1;
    end else begin
      if (a == 0) up_m = 0;
      if (a == 1) up_m = 1;
      if (a >= 2) begin
        md_m = a[0];
        for (int i = 0; i < 4; i++) out_m[i] = st_m[i];
        sd_m = 0;
      end
    end
  endtask

  task automatic send(input logic [15:0] w, input int len, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = w; cmd_len = 6'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
    model_apply(w, len);
    compare(req);
  endtask

  task automatic move_lock(input logic v, input string req);
    logic was;
    was = sd_allow;
    @(negedge clk);
    sd_allow = v;
    repeat (5) @(negedge clk);
    if (was && !v) sd_m = 0;
    compare(req);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    compare("R1");

    // R12: results appear one edge after the strobe (send samples there).
    send(16'h1ABC, 16, "R12 R2");
    send(16'h4000, 16, "R4");

    // Sweep: every opcode x eight data patterns x three lengths (R2-R10).
    for (int p = 0; p < 8; p++) begin
      for (int op = 0; op < 16; op++) begin
        for (int k = 0; k < 3; k++) begin
          logic [11:0] d;
          int len;
          d = (p == 0) ? 12'hFFF : (p == 1) ? 12'h000 : 12'((p * 1237 + op * 291 + k * 77) % 4096);
          len = (k == 0) ? 16 : (k == 1) ? 15 : 17;
          send({4'(op), d}, len, (k == 0) ? "R2-sweep R3 R5 R7 R8 R10" : "R9");
        end
      end
    end

    // R6: shutdown gated by lockout, codes kept.
    send(16'h3123, 16, "R3");
    send(16'hC000, 16, "R6");
    send(16'h5456, 16, "R2 R6");
    move_lock(1'b0, "R11");
    send(16'hC000, 16, "R6 lockout low");
    move_lock(1'b1, "R11 rise");
    send(16'hC000, 16, "R6");
    send(16'h0000, 16, "R7 nop");
    send(16'hE000, 16, "R8 R10");
    send(16'hC000, 16, "R6");
    send(16'hC000, 15, "R9");
    move_lock(1'b0, "R11");
    move_lock(1'b1, "R11");
    send(16'h8777, 16, "R5");

    // R1: clear during operation.
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    compare("R1 mid-run");
    rst_n = 1'b1;
    send(16'h2000, 16, "R7");
    send(16'h4000, 16, "R1 R4 staging cleared");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule